// File: doc/BRIEF.md
# Framed Serial Transmitter

This block shifts data words out on a single serial line, paced by a transmit-clock enable. A start request first drives a frame-sync pulse of programmable length. Right after the pulse it sends a programmable number of words, each with a programmable number of bits, in either bit order. Between frames the data line rests at a programmable idle level. An optional open-drain mode drives the output enable only while the line carries a one.

Words arrive on a valid/ready holding interface and are taken at the start of each word slot. If no word is waiting when a slot begins, the block flags an underrun and sends the idle level for that slot. A transfer-size code, computed from the word-length setting, tells an external DMA requester whether to move bytes, halfwords or words. A word length of one bit is rejected with a configuration-error pulse, and no frame starts.

Top module: `framed_serial_tx`

## Requirements
- R1: The frame-sync output stays high for exactly L+1 enabled ticks, where L = {fs_len_hi_i, fs_len_i} is a 9-bit value.
- R2: With L equal to zero, the frame-sync output is high for exactly one tick.
- R3: Each accepted start sends word_cnt_i+1 words.
- R4: Each word has dat_len_i+1 bits. The first bit is on the line in the tick right after frame-sync falls, and words follow each other with no gap.
- R5: A start request while dat_len_i is 0 raises cfg_err_o for one cycle and starts no frame: busy_o and fs_o stay low.
- R6: With msb_first_i=1 the bit at index dat_len_i goes out first. With msb_first_i=0 bit 0 goes out first.
- R7: While no frame is in progress, txd_o equals idle_lvl_i.
- R8: With open_drain_i=1, txd_oe_o equals txd_o. With open_drain_i=0, txd_oe_o is 1.
- R9: xfer_size_o is 0 (bytes) when dat_len_i is 7 or less, 1 (halfwords) for 8 to 15, and 2 (words) for 16 or more.
- R10: All configuration inputs are captured when the start is accepted. Changes to them during a frame do not change the frame.
- R11: word_ready_o is asserted only together with word_valid_i. When a slot begins with no valid word, underrun_o pulses for one cycle and the slot carries the idle level.
- R12: The block accepts a start and changes state only in cycles where tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Transmit-clock enable |
| start_i | input | 1 | Frame start request |
| fs_len_i | input | FS_W | Frame-sync length, low part |
| fs_len_hi_i | input | 1 | Frame-sync length, extension bit |
| word_cnt_i | input | CNT_W | Words per frame minus one |
| dat_len_i | input | LEN_W | Bits per word minus one |
| msb_first_i | input | 1 | Bit order: 1 sends the MSB first |
| idle_lvl_i | input | 1 | Data line level between frames |
| open_drain_i | input | 1 | Open-drain output-enable mode |
| word_i | input | 2**LEN_W | Word to send |
| word_valid_i | input | 1 | word_i holds a word |
| word_ready_o | output | 1 | Word taken at this clock edge |
| fs_o | output | 1 | Frame-sync output |
| txd_o | output | 1 | Serial data output |
| txd_oe_o | output | 1 | Data output enable |
| busy_o | output | 1 | Frame in progress |
| cfg_err_o | output | 1 | Start rejected: one-bit word length |
| underrun_o | output | 1 | Word slot began with no valid word |
| xfer_size_o | output | 2 | DMA transfer size code |

## Verification
The assertions assume that configuration inputs change only between frames or in ways the latch makes harmless, that word_valid_i does not depend combinationally on word_ready_o, and that tick_i is a plain enable. The stimulus holds every input steady around the clock edges by driving it at the falling edge. Words come from a preloaded queue whose valid flag simply reflects how many words are left. The one test that changes configuration mid-frame does so only after the start has been accepted.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } ftx_state_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } ftx_size_e;
endpackage

// File: rtl/ftx_cfg_latch.sv
module ftx_cfg_latch #(
  parameter int LEN_W = 5,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [LEN_W-1:0] dat_len_i,
  input  logic             msb_first_i,
  input  logic             idle_lvl_i,
  input  logic             open_drain_i,
  output logic [LEN_W-1:0] dat_len_q_o,
  output logic             msb_first_q_o,
  output logic             idle_lvl_q_o,
  output logic             open_drain_q_o,
  output logic             len_ok_o,
  output logic [1:0]       xfer_size_o
);
  import ftx_pkg::*;

  localparam int HALF_MIN = 8;
  localparam int WORD_MIN = 16;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_len_q_o    <= '0;
      msb_first_q_o  <= 1'b0;
      idle_lvl_q_o   <= 1'b0;
      open_drain_q_o <= 1'b0;
    end else if (cap_i) begin
      dat_len_q_o    <= dat_len_i;
      msb_first_q_o  <= msb_first_i;
      idle_lvl_q_o   <= idle_lvl_i;
      open_drain_q_o <= open_drain_i;
    end
  end

  assign len_ok_o = (dat_len_i != '0);

  always_comb begin
    if (int'(dat_len_i) >= WORD_MIN)      xfer_size_o = SZ_WORD;
    else if (int'(dat_len_i) >= HALF_MIN) xfer_size_o = SZ_HALF;
    else                                  xfer_size_o = SZ_BYTE;
  end
endmodule

// File: rtl/ftx_seq.sv
module ftx_seq #(
  parameter int LEN_W = 5,
  parameter int CNT_W = 4,
  parameter int FS_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             len_ok_i,
  input  logic [FS_W:0]    fs_len_i,
  input  logic [CNT_W-1:0] word_cnt_i,
  input  logic [LEN_W-1:0] dat_len_q_i,
  input  logic             word_valid_i,
  output ftx_pkg::ftx_state_e state_o,
  output logic             cap_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             cfg_err_o,
  output logic             underrun_o
);
  import ftx_pkg::*;

  ftx_state_e       state_q;
  logic [FS_W:0]    fs_cnt_q;
  logic [CNT_W-1:0] words_left_q;
  logic [LEN_W-1:0] bit_cnt_q;
  logic             req;

  assign req     = (state_q == ST_IDLE) && tick_i && start_i;
  assign cap_o   = req && len_ok_i;
  assign load_o  = tick_i && (((state_q == ST_SYNC) && (fs_cnt_q == '0)) ||
                              ((state_q == ST_DATA) && (bit_cnt_q == '0) &&
                               (words_left_q != '0)));
  assign shift_o = tick_i && (state_q == ST_DATA) && (bit_cnt_q != '0);
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      fs_cnt_q     <= '0;
      words_left_q <= '0;
      bit_cnt_q    <= '0;
      cfg_err_o    <= 1'b0;
      underrun_o   <= 1'b0;
    end else begin
      cfg_err_o  <= req && !len_ok_i;
      underrun_o <= load_o && !word_valid_i;
      unique case (state_q)
        ST_IDLE: if (cap_o) begin
          state_q      <= ST_SYNC;
          fs_cnt_q     <= fs_len_i;
          words_left_q <= word_cnt_i;
        end
        ST_SYNC: if (tick_i) begin
          if (fs_cnt_q == '0) begin
            state_q   <= ST_DATA;
            bit_cnt_q <= dat_len_q_i;
          end else begin
            fs_cnt_q <= fs_cnt_q - 1'b1;
          end
        end
        ST_DATA: if (tick_i) begin
          if (bit_cnt_q != '0) begin
            bit_cnt_q <= bit_cnt_q - 1'b1;
          end else if (words_left_q == '0) begin
            state_q <= ST_IDLE;
          end else begin
            words_left_q <= words_left_q - 1'b1;
            bit_cnt_q    <= dat_len_q_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ftx_shreg.sv
module ftx_shreg #(
  parameter int LEN_W = 5,
  localparam int DW   = 1 << LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             word_valid_i,
  input  logic [DW-1:0]    word_i,
  input  logic             msb_first_i,
  input  logic [LEN_W-1:0] dat_len_i,
  input  logic             idle_lvl_i,
  output logic             bit_o
);
  logic [DW-1:0] sr_q;
  logic          empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      empty_q <= 1'b1;
    end else if (load_i) begin
      sr_q    <= word_valid_i ? word_i : '0;
      empty_q <= !word_valid_i;
    end else if (shift_i) begin
      sr_q <= msb_first_i ? (sr_q << 1) : (sr_q >> 1);
    end
  end

  // empty slot carries idle level
  assign bit_o = empty_q ? idle_lvl_i : (msb_first_i ? sr_q[dat_len_i] : sr_q[0]);
endmodule

// File: rtl/framed_serial_tx.sv
module framed_serial_tx #(
  parameter int LEN_W = 5,
  parameter int CNT_W = 4,
  parameter int FS_W  = 8,
  parameter bit OD_EN = 1'b1,
  localparam int DW   = 1 << LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [FS_W-1:0]  fs_len_i,
  input  logic             fs_len_hi_i,
  input  logic [CNT_W-1:0] word_cnt_i,
  input  logic [LEN_W-1:0] dat_len_i,
  input  logic             msb_first_i,
  input  logic             idle_lvl_i,
  input  logic             open_drain_i,
  input  logic [DW-1:0]    word_i,
  input  logic             word_valid_i,
  output logic             word_ready_o,
  output logic             fs_o,
  output logic             txd_o,
  output logic             txd_oe_o,
  output logic             busy_o,
  output logic             cfg_err_o,
  output logic             underrun_o,
  output logic [1:0]       xfer_size_o
);
  import ftx_pkg::*;

  ftx_state_e       state;
  logic             cap, load, shift, len_ok, sr_bit;
  logic [LEN_W-1:0] dat_len_q;
  logic             msb_q, idle_q, od_q, idle_eff, od_eff;

  ftx_cfg_latch #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_cfg (
    .clk_i, .rst_ni,
    .cap_i          (cap),
    .dat_len_i,
    .msb_first_i,
    .idle_lvl_i,
    .open_drain_i,
    .dat_len_q_o    (dat_len_q),
    .msb_first_q_o  (msb_q),
    .idle_lvl_q_o   (idle_q),
    .open_drain_q_o (od_q),
    .len_ok_o       (len_ok),
    .xfer_size_o
  );

  ftx_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W), .FS_W(FS_W)) i_seq (
    .clk_i, .rst_ni, .tick_i, .start_i,
    .len_ok_i     (len_ok),
    .fs_len_i     ({fs_len_hi_i, fs_len_i}),
    .word_cnt_i,
    .dat_len_q_i  (dat_len_q),
    .word_valid_i,
    .state_o      (state),
    .cap_o        (cap),
    .load_o       (load),
    .shift_o      (shift),
    .cfg_err_o,
    .underrun_o
  );

  ftx_shreg #(.LEN_W(LEN_W)) i_shreg (
    .clk_i, .rst_ni,
    .load_i       (load),
    .shift_i      (shift),
    .word_valid_i,
    .word_i,
    .msb_first_i  (msb_q),
    .dat_len_i    (dat_len_q),
    .idle_lvl_i   (idle_q),
    .bit_o        (sr_bit)
  );

  assign busy_o       = (state != ST_IDLE);
  assign fs_o         = (state == ST_SYNC);
  assign word_ready_o = load && word_valid_i;
  assign idle_eff     = busy_o ? idle_q : idle_lvl_i;
  assign txd_o        = (state == ST_DATA) ? sr_bit : idle_eff;

  generate
    if (OD_EN) begin : g_od
      assign od_eff   = busy_o ? od_q : open_drain_i;
      assign txd_oe_o = od_eff ? txd_o : 1'b1;
    end else begin : g_push_pull
      assign od_eff   = 1'b0;
      assign txd_oe_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/ftx_checker.sv
module ftx_checker #(
  parameter int LEN_W = 5,
  parameter bit OD_EN = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [LEN_W-1:0] dat_len_i,
  input logic             idle_lvl_i,
  input logic             open_drain_i,
  input logic             word_valid_i,
  input logic             word_ready_o,
  input logic             fs_o,
  input logic             txd_o,
  input logic             txd_oe_o,
  input logic             busy_o,
  input logic             cfg_err_o,
  input logic             underrun_o,
  input logic [1:0]       xfer_size_o
);
  assert_fs_in_frame_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_o |-> busy_o);
  assert_data_after_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fs_o) |-> busy_o);
  assert_err_no_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!busy_o && !fs_o));
  assert_idle_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (txd_o == idle_lvl_i));
  assert_od_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && open_drain_i && OD_EN) |-> (txd_oe_o == txd_o));
  assert_size_word_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(dat_len_i) >= 16) |-> (xfer_size_o == 2'd2));
  assert_ready_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o |-> word_valid_i);
  assert_underrun_in_frame_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> busy_o);
  assert_hold_no_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(fs_o) && $stable(busy_o)));
endmodule

bind framed_serial_tx ftx_checker #(.LEN_W(LEN_W), .OD_EN(OD_EN)) i_ftx_checker (
  .clk_i, .rst_ni, .tick_i, .dat_len_i, .idle_lvl_i, .open_drain_i,
  .word_valid_i, .word_ready_o, .fs_o, .txd_o, .txd_oe_o, .busy_o,
  .cfg_err_o, .underrun_o, .xfer_size_o
);

// File: tb/test_framed_serial_tx.sv
module test_framed_serial_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1, start = 1'b0, fs_hi = 1'b0;
  logic [7:0]  fs_len = '0;
  logic [3:0]  wcnt = '0;
  logic [4:0]  dlen = 5'd7;
  logic        msb = 1'b1, idle = 1'b0, od = 1'b0;
  logic [31:0] wq [8];
  logic        wrst = 1'b0;
  int          widx = 0, wsup = 0;
  logic        half = 1'b0;
  logic        ready, fs, txd, oe, busy, err, urun;
  logic [1:0]  xsz;
  logic [31:0] word;
  logic        valid;

  int n_chk = 0, n_fail = 0;
  int fcnt, nbits, ucnt, oe_bad;
  logic bits [512];

  always #10 clk = ~clk;

  assign word  = wq[widx[2:0]];
  assign valid = (widx < wsup);

  always @(posedge clk) begin
    if (wrst)       widx <= 0;
    else if (ready) widx <= widx + 1;
  end

  always @(negedge clk) tick <= half ? ~tick : 1'b1;

  framed_serial_tx i_framed_serial_tx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start),
    .fs_len_i(fs_len), .fs_len_hi_i(fs_hi), .word_cnt_i(wcnt), .dat_len_i(dlen),
    .msb_first_i(msb), .idle_lvl_i(idle), .open_drain_i(od),
    .word_i(word), .word_valid_i(valid), .word_ready_o(ready),
    .fs_o(fs), .txd_o(txd), .txd_oe_o(oe), .busy_o(busy), .cfg_err_o(err),
    .underrun_o(urun), .xfer_size_o(xsz)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // runs one frame and records fs length, bit stream, underruns, oe mismatches
  task automatic run_frame(input bit scramble);
    wrst = 1'b1;
    @(negedge clk);
    wrst = 1'b0;
    start = 1'b1;
    for (int i = 0; i < 8 && !busy; i++) @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      msb = ~msb; idle = ~idle; dlen = dlen + 5'd3; od = ~od;
    end
    fcnt = 0; nbits = 0; ucnt = 0; oe_bad = 0;
    for (int c = 0; c < 4000 && busy; c++) begin
      if (fs) fcnt++;
      else if (nbits < 512) begin bits[nbits] = txd; nbits++; end
      if (urun) ucnt++;
      if (oe !== (od ? txd : 1'b1)) oe_bad++;
      @(negedge clk);
    end
    if (urun) ucnt++;
  endtask

  task automatic check_stream(input string req, input int d, input int n, input bit m,
                              input bit idl);
    int errs = 0;
    int k = 0;
    chk(nbits == (n + 1) * (d + 1), req, nbits, (n + 1) * (d + 1));
    for (int w = 0; w <= n; w++) begin
      for (int b = 0; b <= d; b++) begin
        logic e;
        if (w >= wsup) e = idl;
        else           e = m ? wq[w][d - b] : wq[w][b];
        if (k < nbits && bits[k] !== e) errs++;
        k++;
      end
    end
    chk(errs == 0, req, errs, 0);
  endtask

  task automatic t_reset();
    chk(fs == 1'b0 && busy == 1'b0, "R7 reset idle", {fs, busy}, 0);
    idle = 1'b1; @(negedge clk);
    chk(txd == 1'b1, "R7 idle level 1", txd, 1);
    idle = 1'b0; @(negedge clk);
    chk(txd == 1'b0, "R7 idle level 0", txd, 0);
  endtask

  task automatic t_basic_msb();
    fs_hi = 0; fs_len = 8'd2; wcnt = 4'd2; dlen = 5'd7; msb = 1; idle = 0; od = 0;
    wq[0] = 32'hA5; wq[1] = 32'h3C; wq[2] = 32'h81; wsup = 3;
    run_frame(0);
    chk(fcnt == 3, "R1 fs length L=2", fcnt, 3);
    check_stream("R3 R4 R6 msb first", 7, 2, 1, 0);
    chk(ucnt == 0, "R11 no underrun", ucnt, 0);
  endtask

  task automatic t_lsb_long();
    fs_hi = 0; fs_len = 8'd0; wcnt = 4'd1; dlen = 5'd19; msb = 0; idle = 1; od = 0;
    wq[0] = 32'h000F_1234; wq[1] = 32'h000A_BCDE; wsup = 2;
    run_frame(0);
    chk(fcnt == 1, "R2 fs one tick", fcnt, 1);
    check_stream("R4 R6 lsb first", 19, 1, 0, 1);
  endtask

  task automatic t_fs_ext();
    fs_hi = 1; fs_len = 8'd0; wcnt = 4'd0; dlen = 5'd3; msb = 1; idle = 0;
    wq[0] = 32'h9; wsup = 1;
    run_frame(0);
    chk(fcnt == 257, "R1 fs extension bit", fcnt, 257);
    fs_hi = 0;
  endtask

  task automatic t_cfg_err();
    dlen = 5'd0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1, "R5 cfg error pulse", err, 1);
    chk(busy == 1'b0 && fs == 1'b0, "R5 no frame", {busy, fs}, 0);
    @(negedge clk);
    chk(err == 1'b0, "R5 error one cycle", err, 0);
    dlen = 5'd7;
  endtask

  task automatic t_size();
    dlen = 5'd1;  #1 chk(xsz == 2'd0, "R9 byte 1", xsz, 0);
    dlen = 5'd7;  #1 chk(xsz == 2'd0, "R9 byte 7", xsz, 0);
    dlen = 5'd8;  #1 chk(xsz == 2'd1, "R9 half 8", xsz, 1);
    dlen = 5'd15; #1 chk(xsz == 2'd1, "R9 half 15", xsz, 1);
    dlen = 5'd16; #1 chk(xsz == 2'd2, "R9 word 16", xsz, 2);
    dlen = 5'd31; #1 chk(xsz == 2'd2, "R9 word 31", xsz, 2);
    @(negedge clk);
  endtask

  task automatic t_open_drain();
    fs_len = 8'd1; wcnt = 4'd1; dlen = 5'd7; msb = 1; idle = 1; od = 1;
    wq[0] = 32'h5A; wq[1] = 32'hF0; wsup = 2;
    @(negedge clk);
    chk(oe == 1'b1, "R8 od idle high", oe, 1);
    run_frame(0);
    chk(oe_bad == 0, "R8 oe follows data", oe_bad, 0);
    idle = 0; @(negedge clk);
    chk(oe == 1'b0, "R8 od idle low", oe, 0);
    od = 0; @(negedge clk);
    chk(oe == 1'b1, "R8 push-pull oe", oe, 1);
  endtask

  task automatic t_hold();
    fs_len = 8'd1; wcnt = 4'd1; dlen = 5'd7; msb = 1; idle = 0; od = 0;
    wq[0] = 32'hC3; wq[1] = 32'h17; wsup = 2;
    run_frame(1);
    check_stream("R10 config held", 7, 1, 1, 0);
    msb = 1; idle = 0; dlen = 5'd7; od = 0;
  endtask

  task automatic t_underrun();
    fs_len = 8'd0; wcnt = 4'd3; dlen = 5'd7; msb = 1; idle = 1; od = 0;
    wq[0] = 32'h11; wq[1] = 32'h22; wsup = 2;
    run_frame(0);
    chk(ucnt == 2, "R11 underrun pulses", ucnt, 2);
    check_stream("R11 idle in empty slot", 7, 3, 1, 1);
    idle = 0;
  endtask

  task automatic t_half_rate();
    fs_len = 8'd1; wcnt = 4'd0; dlen = 5'd3; msb = 1; idle = 0;
    wq[0] = 32'h6; wsup = 1;
    half = 1'b1;
    run_frame(0);
    half = 1'b0;
    chk(fcnt == 4, "R12 fs spans ticks", fcnt, 4);
    chk(nbits == 8, "R12 bits span ticks", nbits, 8);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_msb();
        t_lsb_long();
        t_fs_ext();
        t_cfg_err();
        t_size();
        t_open_drain();
        t_hold();
        t_underrun();
        t_half_rate();
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule